// File: doc/BRIEF.md
# Split-Carry Approximate Adder with Selectable Lower-Bit Patching

This block adds two 8-bit operands with a deliberately shortened carry chain. The word is cut into a lower and an upper 4-bit half. Bits 0 to 2 use a cheap cell whose carry-out ignores its carry-in. Bit 3 is a splitter cell that produces an exact carry and a predicted carry. Bit 4 is a joiner cell that forms its sum from the exact carry. The carry it sends up the chain is built from the predicted carry only. Because of this, the upper ripple never waits on the lower half, and no multiplexer sits on the critical path.

When the exact carry at the split is 1 and the predicted carry is 0, the upper half has lost a carry. A patch unit can then raise low-order sum bits toward the missing value. A compile-time parameter picks one of four patch levels: no patching, bit 4 only, bits 3 and 4, or bits 0 through 4. The ports are the same at every level. The result can be taken combinationally or from a register stage qualified by a valid strobe.

Top module: `dca_adder`

## Requirements
- R1: Carry into bit 0 is 0. Each of bits 0..2 outputs a XOR b XOR carry-in, and its carry-out is a AND b only.
- R2: The bit-3 cell outputs a XOR b XOR carry-in as its sum. Its exact carry is (a OR b) AND carry-in, OR a AND b. Its predicted carry is a AND b. A predicted carry of 1 always comes with an exact carry of 1.
- R3: Before patching, bit 4 of the sum is a4 XOR b4 XOR the exact split carry. The carry out of bit 4 is (a4 OR b4) AND predicted carry, OR a4 AND b4.
- R4: Bits 5..7 are exact full adders rippling from bit 4. `cout` is the carry out of bit 7.
- R5: ERU_MODE selects the patched bits: 0 none, 1 bit 4, 2 bits 3..4, 3 bits 0..4. Bits outside the selected set never differ from their unpatched value.
- R6: Patching is active only when the exact split carry is 1 and the predicted split carry is 0. While it is active, every selected bit reads 1.
- R7: Patching never turns a 1 into a 0.
- R8: 0x00 + 0x7F gives sum 0x7F and cout 0 at every patch level.
- R9: With REG_OUT=1, a result appears on `sum`/`cout` one clock after `in_valid` is high, and `out_valid` is high for that cycle. When `in_valid` is low, the outputs hold their values. Reset clears `sum`, `cout` and `out_valid` to 0.
- R10: With REG_OUT=0, `sum` and `cout` follow the operands combinationally, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| out_valid | output | 1 | Result on `sum`/`cout` is new |
| sum | output | 8 | Approximate sum, patched per ERU_MODE |
| cout | output | 1 | Carry out of the top bit |

## Verification
Two functions can act in the same cycle. The carry-split error drops a carry from the upper half, and the patch unit raises low bits to compensate. Both fire together whenever bit 3 propagates a carry that bit 2 generated. Operands such as 0x1C + 0x04 and 0x0C + 0x04 provoke this on purpose. One instance per patch level is built, and each level's hand-derived result is compared against it. The exhaustive sweep then covers every operand pair, and its results are judged against a per-bit model of the equations. That model is written independently of the RTL.

// File: rtl/dca_pkg.sv
package dca_pkg;

  localparam int MODE_NONE  = 0;
  localparam int MODE_ONE   = 1;
  localparam int MODE_TWO   = 2;
  localparam int MODE_WIDE  = 3;

  // Bit set of the patched positions within the nb-bit window ending at the split's upper bit.
  function automatic int unsigned fix_mask(input int mode, input int nb);
    case (mode)
      MODE_NONE: return 0;
      MODE_ONE:  return 1 << (nb - 1);
      MODE_TWO:  return 3 << (nb - 2);
      default:   return (1 << nb) - 1;
    endcase
  endfunction

endpackage

// File: rtl/dca_lower_seg.sv
module dca_lower_seg #(
  parameter int LO = 4
) (
  input  logic [LO-1:0] a,
  input  logic [LO-1:0] b,
  output logic [LO-1:0] pre_sum,
  output logic          c_exact,
  output logic          c_pred
);
  logic [LO-1:0] chain;

  assign chain[0] = 1'b0;

  // Cheap cells: carry ignores carry-in.
  for (genvar i = 0; i < LO - 1; i++) begin : g_cheap
    always_comb begin
      pre_sum[i]   = a[i] ^ b[i] ^ chain[i];
      chain[i + 1] = a[i] & b[i];
    end
  end

  // Splitter cell at the top of the lower half.
  always_comb begin
    pre_sum[LO-1] = a[LO-1] ^ b[LO-1] ^ chain[LO-1];
    c_pred        = a[LO-1] & b[LO-1];
    c_exact       = c_pred | ((a[LO-1] | b[LO-1]) & chain[LO-1]);
  end
endmodule

// File: rtl/dca_upper_seg.sv
module dca_upper_seg #(
  parameter int HI = 4
) (
  input  logic [HI-1:0] a,
  input  logic [HI-1:0] b,
  input  logic          c_exact,
  input  logic          c_pred,
  output logic [HI-1:0] pre_sum,
  output logic          cout
);
  logic [HI:0] chain;

  // Joiner cell: sum from the exact carry, carry-out from the predicted one.
  always_comb begin
    pre_sum[0] = a[0] ^ b[0] ^ c_exact;
    chain[1]   = (a[0] & b[0]) | ((a[0] | b[0]) & c_pred);
  end

  for (genvar i = 1; i < HI; i++) begin : g_ripple
    always_comb begin
      pre_sum[i]   = a[i] ^ b[i] ^ chain[i];
      chain[i + 1] = (a[i] & b[i]) | ((a[i] | b[i]) & chain[i]);
    end
  end

  assign chain[0] = c_exact;
  assign cout     = chain[HI];
endmodule

// File: rtl/dca_fix_unit.sv
module dca_fix_unit #(
  parameter int MODE = 3,
  parameter int NB   = 5
) (
  input  logic [NB-1:0] pre_bits,
  input  logic          c_exact,
  input  logic          c_pred,
  output logic [NB-1:0] fixed_bits
);
  import dca_pkg::*;

  localparam int unsigned MASK_I = fix_mask(MODE, NB);
  localparam logic [NB-1:0] MASK = MASK_I[NB-1:0];

  logic lost_carry;

  always_comb begin
    lost_carry = c_exact & ~c_pred;
    fixed_bits = pre_bits | (lost_carry ? MASK : '0);
  end
endmodule

// File: rtl/dca_adder.sv
module dca_adder #(
  parameter int W        = 8,
  parameter int LO       = 4,
  parameter int ERU_MODE = 3,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  output logic [W-1:0] sum,
  output logic         cout
);
  import dca_pkg::*;

  localparam int HI = W - LO;
  localparam int NB = LO + 1;
  localparam int unsigned MASK_I = fix_mask(ERU_MODE, NB);
  localparam logic [NB-1:0] MASK = MASK_I[NB-1:0];

  logic [LO-1:0] lo_pre;
  logic [HI-1:0] hi_pre;
  logic          c_exact, c_pred, hi_cout;
  logic [NB-1:0] win_pre, win_fixed;
  logic [W-1:0]  comb_sum;

  dca_lower_seg #(.LO(LO)) u_lower (
    .a(a[LO-1:0]), .b(b[LO-1:0]), .pre_sum(lo_pre),
    .c_exact(c_exact), .c_pred(c_pred)
  );

  dca_upper_seg #(.HI(HI)) u_upper (
    .a(a[W-1:LO]), .b(b[W-1:LO]), .c_exact(c_exact), .c_pred(c_pred),
    .pre_sum(hi_pre), .cout(hi_cout)
  );

  assign win_pre = {hi_pre[0], lo_pre};

  dca_fix_unit #(.MODE(ERU_MODE), .NB(NB)) u_fix (
    .pre_bits(win_pre), .c_exact(c_exact), .c_pred(c_pred),
    .fixed_bits(win_fixed)
  );

  if (HI > 1) begin : g_wide_upper
    assign comb_sum = {hi_pre[HI-1:1], win_fixed};
  end else begin : g_narrow_upper
    assign comb_sum = win_fixed;
  end

  if (REG_OUT) begin : g_reg
    logic [W-1:0] sum_q, sum_d;
    logic         cout_q, cout_d, vld_q, vld_d;

    always_comb begin
      vld_d  = in_valid;
      sum_d  = sum_q;
      cout_d = cout_q;
      if (in_valid) begin
        sum_d  = comb_sum;
        cout_d = hi_cout;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q  <= '0;
        cout_q <= 1'b0;
        vld_q  <= 1'b0;
      end else begin
        sum_q  <= sum_d;
        cout_q <= cout_d;
        vld_q  <= vld_d;
      end
    end

    assign sum       = sum_q;
    assign cout      = cout_q;
    assign out_valid = vld_q;

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(sum) && $stable(cout)));
  end else begin : g_comb
    assign sum       = comb_sum;
    assign cout      = hi_cout;
    assign out_valid = in_valid;
  end

  p_pred_implies_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_pred |-> c_exact);
  p_fix_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_fixed != win_pre) |-> (c_exact && !c_pred));
  p_fix_never_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_pre & ~win_fixed) == '0);
  p_fix_in_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_pre ^ win_fixed) & ~MASK) == '0);
endmodule

// File: tb/dca_adder_test.sv
module dca_adder_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] a_i = '0, b_i = '0;

  logic [7:0] sum_w [4];
  logic       cout_w [4];
  logic       ov_w [4];
  logic [7:0] sum_c;
  logic       cout_c, ov_c;

  int checks = 0, fails = 0;
  int differ [4];
  bit done = 1'b0;

  typedef struct {
    logic [7:0]       a, b;
    logic [3:0][8:0]  exp;
    string            tag;
  } item_t;
  item_t sb_q[$];
  logic [8:0] last [4];

  always #(CLK_P/2) clk = ~clk;

  for (genvar m = 0; m < 4; m++) begin : g_mode
    dca_adder #(.ERU_MODE(m), .REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a_i), .b(b_i),
      .out_valid(ov_w[m]), .sum(sum_w[m]), .cout(cout_w[m])
    );
  end

  dca_adder #(.ERU_MODE(3), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a_i), .b(b_i),
    .out_valid(ov_c), .sum(sum_c), .cout(cout_c)
  );

  task automatic check(input bit ok, input string tag, input int m,
                       input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", tag, m, act, exp);
    end
  endtask

  // Independent model: lower bits as a^b^(shifted generate), upper as a plain add.
  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b, input int mode);
    logic [3:0] lo;
    logic       g2, ex, pr, b4, ena;
    logic [4:0] up, mk;
    lo = a[3:0] ^ b[3:0] ^ {a[2:0] & b[2:0], 1'b0};
    g2 = a[2] & b[2];
    pr = a[3] & b[3];
    ex = pr | ((a[3] | b[3]) & g2);
    b4 = a[4] ^ b[4] ^ ex;
    up = {1'b0, a[7:4]} + {1'b0, b[7:4]} + {4'd0, pr};
    ena = ex & ~pr;
    case (mode)
      0: mk = 5'b00000;
      1: mk = 5'b10000;
      2: mk = 5'b11000;
      default: mk = 5'b11111;
    endcase
    return {up[4], up[3:1], ({b4, lo} | (ena ? mk : 5'b0))};
  endfunction

  task automatic drive(input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0][8:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    a_i = a; b_i = b; in_valid = 1'b1;
    it.a = a; it.b = b; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    #1;
    check({cout_c, sum_c} === exp[3], {tag, " R10 comb"}, 3, {cout_c, sum_c}, exp[3]);
    check(ov_c === 1'b1, "R10 valid passthrough", 3, {8'd0, ov_c}, 9'd1);
  endtask

  function automatic logic [3:0][8:0] p4(input logic [8:0] m0, input logic [8:0] m1,
                                         input logic [8:0] m2, input logic [8:0] m3);
    logic [3:0][8:0] r;
    r[0] = m0; r[1] = m1; r[2] = m2; r[3] = m3;
    return r;
  endfunction

  // Monitor: samples a quarter period after each rising edge.
  initial begin
    for (int m = 0; m < 4; m++) begin last[m] = '0; differ[m] = 0; end
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rst_n) begin
        if (ov_w[0]) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R9 unexpected result", 0, {cout_w[0], sum_w[0]}, 9'd0);
          end else begin
            item_t it;
            it = sb_q.pop_front();
            for (int m = 0; m < 4; m++) begin
              check(ov_w[m] === 1'b1, "R9 valid aligned", m, {8'd0, ov_w[m]}, 9'd1);
              check({cout_w[m], sum_w[m]} === it.exp[m], it.tag, m,
                    {cout_w[m], sum_w[m]}, it.exp[m]);
              if (it.exp[m] != ({1'b0, it.a} + {1'b0, it.b})) differ[m]++;
              last[m] = it.exp[m];
            end
          end
        end else begin
          for (int m = 0; m < 4; m++)
            check({cout_w[m], sum_w[m]} === last[m] && ov_w[m] === 1'b0,
                  "R9 hold while idle", m, {cout_w[m], sum_w[m]}, last[m]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    for (int m = 0; m < 4; m++)
      check({cout_w[m], sum_w[m]} === 9'd0 && ov_w[m] === 1'b0, "R9 reset state", m,
            {cout_w[m], sum_w[m]}, 9'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    drive(8'h00, 8'h7F, p4(9'h07F, 9'h07F, 9'h07F, 9'h07F), "R8 zero plus 0x7F");
    drive(8'h01, 8'h01, p4(9'h002, 9'h002, 9'h002, 9'h002), "R1 carry from bit0");
    drive(8'h03, 8'h01, p4(9'h000, 9'h000, 9'h000, 9'h000), "R1 dropped carry");
    drive(8'h0C, 8'h04, p4(9'h010, 9'h010, 9'h018, 9'h01F), "R2 R6 split patch");
    drive(8'h18, 8'h08, p4(9'h020, 9'h020, 9'h020, 9'h020), "R3 predicted carry up");
    drive(8'h1C, 8'h04, p4(9'h000, 9'h010, 9'h018, 9'h01F), "R3 R5 R6 lost carry");
    drive(8'h0D, 8'h05, p4(9'h012, 9'h012, 9'h01A, 9'h01F), "R7 set bits kept");
    drive(8'h80, 8'h80, p4(9'h100, 9'h100, 9'h100, 9'h100), "R4 top carry");
    drive(8'hF0, 8'h10, p4(9'h100, 9'h100, 9'h100, 9'h100), "R4 upper ripple");
    drive(8'h70, 8'h10, p4(9'h080, 9'h080, 9'h080, 9'h080), "R4 into bit7");

    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);

    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        drive(x[7:0], y[7:0],
              p4(model(x[7:0], y[7:0], 0), model(x[7:0], y[7:0], 1),
                 model(x[7:0], y[7:0], 2), model(x[7:0], y[7:0], 3)),
              "R1 R2 R3 R4 R5 R6 sweep");
      end
    end

    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R9 all results drained", 0, sb_q.size(), 9'd0);
    for (int m = 0; m < 4; m++)
      $display("mode %0d: %0d results differ from exact sum", m, differ[m]);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule